// File: doc/BRIEF.md
# Serial Control Word Receiver

The block takes in 16-bit control words arriving on two wires: a word clock and a serial data line. Both wires are brought into the system clock domain through synchronizer chains. The data level is taken only when the word clock falls. While idle the line sits high. A low level taken while the receiver is hunting counts as a start bit. The sixteen bits that follow fill a shift register, the most significant bit arriving first.

A word is not released at its last data bit. The receiver then waits for sixteen consecutive high stop bits. At the sixteenth it copies the word to a parallel output and raises a valid strobe for one system clock cycle. A low level taken before the sixteenth stop bit drops the pending word, and that same bit becomes the start bit of a new frame. Setup and hold margins around the sampling edge are a timing constraint and are not checked in logic.

Top module: `ctrlw_rx`

## Requirements
- R1: While `rst_n` is low, `word_o` is 0 and `word_vld_o` is 0. After release the receiver is hunting for a start bit, and any frame that was partly received before reset is dropped.
- R2: The data line is used only at falling edges of `wclk_i`. Its level at all other times, including toggles while `wclk_i` is high, has no effect on `word_o` or `word_vld_o`.
- R3: While hunting, a sampled 0 is a start bit. The next 16 sampled bits form the word, first bit into bit 15 and last bit into bit 0, so that a word arriving as 1,0,1,0,0,1,0,1,... yields 16'hA5.. on `word_o`.
- R4: A word is accepted on the falling edge that samples its 16th consecutive high stop bit. No strobe appears on stop bits 1 to 15. `word_vld_o` is high in the cycle after the third rising `clk` edge that follows that falling edge of `wclk_i`: two synchronizer stages plus one register.
- R5: A 0 sampled after the data bits but before the 16th stop bit drops the pending word, gives no strobe, leaves `word_o` unchanged, and acts as the start bit of a new frame.
- R6: `word_vld_o` is high for exactly one `clk` cycle per accepted word. `word_o` holds its value until the next accepted word.
- R7: High bits sampled while hunting, or after acceptance, produce no output for any length of idle. The stop-bit count saturates and never wraps into a second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| wclk_i | input | 1 | Word clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Serial data line, idles high |
| word_o | output | 16 | Last accepted control word |
| word_vld_o | output | 1 | One-cycle strobe marking a newly accepted word |

## Verification
The only timed result is the acceptance strobe. It is due in the cycle after the third rising `clk` edge that follows the falling word-clock edge of the 16th stop bit. For every bit it sends, the bench samples `word_vld_o` 1 ns after the second, third and fourth rising edges following the falling edge. Low is expected at the second and fourth samples, and at the third unless the bit completes a frame. `word_o` is compared at the same third sample. Between falling edges the bench drives the inverse of the bit on the data line, so any sampling at the wrong time shows up as a word mismatch.

// File: rtl/ctrlw_pkg.sv
package ctrlw_pkg;
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ctrlw_rst_sync.sv
module ctrlw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/ctrlw_sync.sv
module ctrlw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/ctrlw_fsm.sv
module ctrlw_fsm
  import ctrlw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NSTOP  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fall_i,
  input  logic                         bit_i,
  output logic [WORD_W-1:0]            word_o,
  output logic                         vld_o,
  output rx_state_e                    state_o,
  output logic [$clog2(NSTOP+1)-1:0]   stop_cnt_o
);
  localparam int BCW = $clog2(WORD_W);
  localparam int SCW = $clog2(NSTOP + 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(WORD_W - 1);
  localparam logic [SCW-1:0] STOP_LAST = SCW'(NSTOP - 1);
  localparam logic [SCW-1:0] STOP_MAX  = SCW'(NSTOP);

  rx_state_e         state_q, state_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [SCW-1:0]    scnt_q, scnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    scnt_d  = scnt_q;
    shreg_d = shreg_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    if (fall_i) begin
      unique case (state_q)
        RX_HUNT: begin
          if (!bit_i) begin
            state_d = RX_DATA;
            bcnt_d  = '0;
          end
        end
        RX_DATA: begin
          shreg_d = {shreg_q[WORD_W-2:0], bit_i};
          if (bcnt_q == BIT_LAST) begin
            state_d = RX_STOP;
            scnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (!bit_i) begin
            state_d = RX_DATA;
            bcnt_d  = '0;
            scnt_d  = '0;
          end else if (scnt_q == STOP_LAST) begin
            state_d = RX_HUNT;
            word_d  = shreg_q;
            vld_d   = 1'b1;
            scnt_d  = '0;
          end else if (scnt_q < STOP_MAX) begin
            scnt_d = scnt_q + 1'b1;
          end
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      bcnt_q  <= '0;
      scnt_q  <= '0;
      shreg_q <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      scnt_q  <= scnt_d;
      shreg_q <= shreg_d;
      word_q  <= word_d;
      vld_q   <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign vld_o      = vld_q;
  assign state_o    = state_q;
  assign stop_cnt_o = scnt_q;
endmodule

// File: rtl/ctrlw_rx.sv
module ctrlw_rx
  import ctrlw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NSTOP       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int SCW = $clog2(NSTOP + 1);

  logic           rst_n_int;
  logic           wclk_s, data_s;
  logic           wclk_prev_q;
  logic           fall_evt;
  rx_state_e      state_w;
  logic [SCW-1:0] stop_cnt_w;

  ctrlw_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  ctrlw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wclk (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (wclk_i),
    .q_o   (wclk_s)
  );

  ctrlw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_data (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (sdata_i),
    .q_o   (data_s)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) wclk_prev_q <= 1'b1;
    else            wclk_prev_q <= wclk_s;
  end

  assign fall_evt = wclk_prev_q & ~wclk_s;

  ctrlw_fsm #(.WORD_W(WORD_W), .NSTOP(NSTOP)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .fall_i     (fall_evt),
    .bit_i      (data_s),
    .word_o     (word_o),
    .vld_o      (word_vld_o),
    .state_o    (state_w),
    .stop_cnt_o (stop_cnt_w)
  );
endmodule

// File: rtl/ctrlw_rx_chk.sv
module ctrlw_rx_chk
  import ctrlw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NSTOP  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fall,
  input logic                       bitv,
  input rx_state_e                  state,
  input logic [$clog2(NSTOP+1)-1:0] stop_cnt,
  input logic [WORD_W-1:0]          word,
  input logic                       vld
);
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld); // R6

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(word)); // R6

  AST_ACCEPT_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(fall && bitv && state == RX_STOP)); // R4

  AST_START_ENTERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !bitv && state != RX_DATA) |=> state == RX_DATA); // R5

  AST_STOP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cnt < ($clog2(NSTOP+1))'(NSTOP)); // R7

  AST_NO_SAMPLE_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(state)); // R2
endmodule

bind ctrlw_rx ctrlw_rx_chk #(.WORD_W(WORD_W), .NSTOP(NSTOP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fall     (fall_evt),
  .bitv     (data_s),
  .state    (state_w),
  .stop_cnt (stop_cnt_w),
  .word     (word_o),
  .vld      (word_vld_o)
);

// File: tb/tb_ctrlw_rx.sv
`timescale 1ns/1ps
module tb_ctrlw_rx;
  localparam int HP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wclk;
  logic        sdat;
  logic [15:0] word;
  logic        vld;

  int total = 0;
  int bad = 0;
  int vcount = 0;
  int exp_pulses = 0;
  logic [15:0] exp_word = '0;
  logic [15:0] pending = '0;

  always #2.5 clk = ~clk;

  ctrlw_rx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wclk_i     (wclk),
    .sdata_i    (sdat),
    .word_o     (word),
    .word_vld_o (vld)
  );

  always @(negedge clk) if (rst_n && vld === 1'b1) vcount++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit acc);
    @(negedge clk);
    wclk = 1'b1;
    sdat = b;
    repeat (HP) @(negedge clk);
    wclk = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R4 no strobe before latency", {31'd0, vld}, 32'd0);
    @(posedge clk);
    #1 chk("R4 strobe at 16th stop only", {31'd0, vld}, {31'd0, acc});
    if (acc) begin
      exp_word = pending;
      exp_pulses++;
      chk("R3 R2 word value", {16'd0, word}, {16'd0, exp_word});
    end
    @(posedge clk);
    #1 chk("R6 single-cycle strobe", {31'd0, vld}, 32'd0);
    chk("R6 word held", {16'd0, word}, {16'd0, exp_word});
    sdat = ~b;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nstop);
    pending = w;
    send_bit(1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) send_bit(w[i], 1'b0);
    for (int s = 1; s <= nstop; s++) send_bit(1'b1, s == 16);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wclk  = 1'b1;
    sdat  = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word cleared in reset", {16'd0, word}, 32'd0);
    chk("R1 strobe low in reset", {31'd0, vld}, 32'd0);
    exp_word = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    wclk  = 1'b1;
    sdat  = 1'b1;
    do_reset();

    // R7 idle high bits while hunting
    for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b0);
    chk("R7 no strobe while idle", vcount, 0);

    // R2 data toggles with word clock held high
    @(negedge clk);
    wclk = 1'b1;
    for (int i = 0; i < 30; i++) begin
      sdat = 1'($urandom);
      @(negedge clk);
    end
    sdat = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 no strobe from toggles", vcount, 0);
    chk("R2 word unchanged", {16'd0, word}, 32'd0);

    // R3 R4 directed frames
    send_frame(16'hA5C3, 16);
    send_frame(16'hFFFF, 16);
    send_frame(16'h0000, 16);
    // R7 long stop run after acceptance, no second strobe
    send_frame(16'h8001, 60);

    // R5 low inside stop window restarts
    pending = 16'h1234;
    send_bit(1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) send_bit(pending[i], 1'b0);
    for (int s = 1; s <= 15; s++) send_bit(1'b1, 1'b0);
    chk("R5 word unchanged after drop", {16'd0, word}, 32'h8001);
    send_frame(16'hBEEF, 16);

    // R5 low on first stop bit
    pending = 16'h5555;
    send_bit(1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) send_bit(pending[i], 1'b0);
    send_frame(16'h6A96, 20);
    chk("R5 second frame delivered", {16'd0, word}, 32'h6A96);

    // R1 reset mid-frame drops it
    pending = 16'hC0DE;
    send_bit(1'b0, 1'b0);
    for (int i = 15; i >= 8; i--) send_bit(pending[i], 1'b0);
    do_reset();
    send_frame(16'h0F0F, 18);
    chk("R1 frame after reset", {16'd0, word}, 32'h0F0F);

    // random frames
    for (int k = 0; k < 20; k++) begin
      send_frame(16'($urandom), 16 + int'($urandom % 20));
    end

    repeat (4) @(negedge clk);
    chk("R6 one strobe per word", vcount, exp_pulses);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule